// File: doc/BRIEF.md
# Pin Edge Event Channel

This block watches one input line, chosen from two banks of pins, for a programmed transition. When the transition occurs it sets a sticky event flag. It raises a level interrupt request while that flag and an enable bit are both set. Software programs and services the channel through a small word-addressed register bus.

The register map has four words. Word 0 is a packed configuration word holding the mode, pin index, bank select and edge polarity. Word 1 sets the interrupt enable and word 2 clears it. Word 3 holds the event flag, which the interrupt handler acknowledges by writing zero. The chosen pin passes through a two-stage synchronizer before edge detection, so each transition is counted once. After any configuration write the edge detector is held off for three cycles, so the change of selected pin cannot look like a transition.

Top module: `gpio_edge_chan`

## Requirements
- R1: After reset, all four register words read zero and `irq` is low.
- R2: Configuration word (address 0) fields are mode [1:0], pin index [12:8], bank select [13] (0 = `pins_a`, 1 = `pins_b`) and polarity [17:16]. The fields read back as written and all other bits read zero.
- R3: With mode 1 and polarity 1, a low-to-high change on the selected pin sets the event flag (address 3, bit 0). The flag reads 1 after the third rising clock edge following the change and still reads 0 after the second.
- R4: Polarity 2 sets the event on a high-to-low change only. Polarity 1 ignores high-to-low changes.
- R5: Polarity 3 sets the event on either change. Polarity 0 never sets it.
- R6: Only the pin named by the bank bit and pin index can set the event. Changes on any other pin of either bank are ignored.
- R7: The event flag stays set until address 3 is written with bit 0 = 0. Writing bit 0 = 1 leaves it unchanged.
- R8: Writing bit 0 = 1 to address 1 sets the interrupt enable, and writing bit 0 = 1 to address 2 clears it. Writing 0 to either has no effect. Addresses 1 and 2 both read the enable in bit 0.
- R9: `irq` is high exactly while the event flag and the interrupt enable are both 1.
- R10: In any mode other than 1, no event is generated and the event flag keeps its value.
- R11: A configuration write that moves the selection to a pin at a different level does not set the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_a | input | NUM_PINS | Pin bank selected by bank bit 0 |
| pins_b | input | NUM_PINS | Pin bank selected by bank bit 1 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives single rising, falling and rise-then-fall sequences on the selected pin under every polarity code. This separates correct edge decoding from a detector that fires on level or on the wrong direction. It measures the set latency to the cycle, so a missing or extra synchronizer stage shows up. It also toggles pins the channel does not select, in both banks, to expose wrong index or bank decoding. It reselects to a pin that is already high, to catch spurious events on reconfiguration. Acknowledge writes of 0 and 1, enable set and clear, and disabled modes are each checked against the flag and `irq`.

// File: rtl/gpio_edge_chan.sv
module gpio_edge_chan #(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_a,
  input  logic [NUM_PINS-1:0] pins_b,
  input  logic                bus_we,
  input  logic [1:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq
);
  localparam logic [1:0] A_CFG = 2'd0;
  localparam logic [1:0] A_SET = 2'd1;
  localparam logic [1:0] A_CLR = 2'd2;
  localparam logic [1:0] A_EVT = 2'd3;
  localparam int PIN_W = 5;
  localparam logic [1:0] MODE_EVENT = 2'd1;
  localparam logic [1:0] SETTLE = 2'd3;

  logic [1:0]       mode_q, pol_q, settle_q;
  logic [PIN_W-1:0] pin_q;
  logic             bank_q, ien_q, evt_q;
  logic             s1_q, s2_q, s3_q;

  wire wr_cfg = bus_we && bus_addr == A_CFG;
  wire wr_set = bus_we && bus_addr == A_SET && bus_wdata[0];
  wire wr_clr = bus_we && bus_addr == A_CLR && bus_wdata[0];
  wire wr_ack = bus_we && bus_addr == A_EVT && !bus_wdata[0];

  wire in_range = 32'(pin_q) < NUM_PINS;
  wire raw_pin  = in_range ? (bank_q ? pins_b[pin_q] : pins_a[pin_q]) : 1'b0;

  wire rose = s2_q & ~s3_q;
  wire fell = ~s2_q & s3_q;
  logic hit;
  always_comb begin
    case (pol_q)
      2'd1:    hit = rose;
      2'd2:    hit = fell;
      2'd3:    hit = rose | fell;
      default: hit = 1'b0;
    endcase
  end
  wire set_evt = mode_q == MODE_EVENT && settle_q == 2'd0 && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= raw_pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      pin_q    <= '0;
      bank_q   <= 1'b0;
      pol_q    <= '0;
      settle_q <= '0;
    end else if (wr_cfg) begin
      mode_q   <= bus_wdata[1:0];
      pin_q    <= bus_wdata[12:8];
      bank_q   <= bus_wdata[13];
      pol_q    <= bus_wdata[17:16];
      settle_q <= SETTLE;
    end else if (settle_q != 2'd0) begin
      settle_q <= settle_q - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= 1'b0;
    else if (wr_set) ien_q <= 1'b1;
    else if (wr_clr) ien_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       evt_q <= 1'b0;
    else if (set_evt) evt_q <= 1'b1;
    else if (wr_ack)  evt_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG: begin
        bus_rdata[1:0]   = mode_q;
        bus_rdata[12:8]  = pin_q;
        bus_rdata[13]    = bank_q;
        bus_rdata[17:16] = pol_q;
      end
      A_SET, A_CLR: bus_rdata[0] = ien_q;
      default:      bus_rdata[0] = evt_q;
    endcase
  end

  assign irq = evt_q & ien_q;

  a_r10_event_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> $past(mode_q) == MODE_EVENT);
  a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_EVENT && !wr_ack) |=> $stable(evt_q));
  a_r7_clear_only_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_q) |-> $past(wr_ack));
  a_r8_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ien_q);
  a_r8_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> !ien_q);
  a_r11_no_event_settling: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> !$rose(evt_q));
  a_r9_irq_low_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[0] && bus_addr == A_EVT |-> !irq);
endmodule

// File: tb/gpio_edge_chan_tb_top.sv
module gpio_edge_chan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pins_a = '0, pins_b = '0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_chan #(.NUM_PINS(NP), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .pins_a(pins_a), .pins_b(pins_b),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cfg(logic [1:0] m, int pin, logic bank, logic [1:0] pol);
    return {14'd0, pol, 2'd0, bank, pin[4:0], 6'd0, m};
  endfunction

  task automatic set_pin(logic bank, int idx, logic v);
    @(negedge clk);
    if (bank) pins_b[idx] = v; else pins_a[idx] = v;
  endtask

  task automatic evt_is(string req, logic exp);
    logic [31:0] d;
    rd(2'd3, d);
    chk(req, {31'd0, d[0]}, {31'd0, exp});
  endtask

  task automatic arm(logic [31:0] c);
    wr(2'd0, c);
    idle(4);
    wr(2'd3, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1 reset reg", d, 32'd0);
    end
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_cfg_readback;
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    chk("R2 field mask", d, 32'h0003_3F03);
    wr(2'd0, cfg(2'd1, 19, 1'b1, 2'd2));
    rd(2'd0, d);
    chk("R2 readback", d, cfg(2'd1, 19, 1'b1, 2'd2));
    wr(2'd0, 32'd0);
    idle(4);
  endtask

  task automatic t_rise;
    arm(cfg(2'd1, 5, 1'b0, 2'd1));
    evt_is("R3 idle before edge", 1'b0);
    set_pin(1'b0, 5, 1'b1);
    idle(2);
    evt_is("R3 not yet after two edges", 1'b0);
    idle(1);
    evt_is("R3 set after three edges", 1'b1);
    wr(2'd3, 32'd0);
    idle(3);
    evt_is("R3 once per transition", 1'b0);
    set_pin(1'b0, 5, 1'b0);
    idle(5);
    evt_is("R4 rising ignores falling", 1'b0);
  endtask

  task automatic t_fall;
    set_pin(1'b0, 7, 1'b1);
    arm(cfg(2'd1, 7, 1'b0, 2'd2));
    set_pin(1'b0, 7, 1'b0);
    idle(5);
    evt_is("R4 falling detected", 1'b1);
    wr(2'd3, 32'd0);
    set_pin(1'b0, 7, 1'b1);
    idle(5);
    evt_is("R4 falling ignores rising", 1'b0);
  endtask

  task automatic t_toggle_none;
    arm(cfg(2'd1, 9, 1'b0, 2'd3));
    set_pin(1'b0, 9, 1'b1);
    idle(5);
    evt_is("R5 toggle rise", 1'b1);
    wr(2'd3, 32'd0);
    set_pin(1'b0, 9, 1'b0);
    idle(5);
    evt_is("R5 toggle fall", 1'b1);
    arm(cfg(2'd1, 9, 1'b0, 2'd0));
    set_pin(1'b0, 9, 1'b1);
    idle(3);
    set_pin(1'b0, 9, 1'b0);
    idle(5);
    evt_is("R5 polarity none", 1'b0);
  endtask

  task automatic t_bank_select;
    arm(cfg(2'd1, 12, 1'b1, 2'd1));
    set_pin(1'b0, 12, 1'b1);
    set_pin(1'b1, 13, 1'b1);
    set_pin(1'b1, 11, 1'b1);
    idle(5);
    evt_is("R6 other pins ignored", 1'b0);
    set_pin(1'b1, 12, 1'b1);
    idle(5);
    evt_is("R6 bank b pin", 1'b1);
  endtask

  task automatic t_sticky_irq;
    wr(2'd3, 32'd1);
    idle(1);
    evt_is("R7 write one keeps flag", 1'b1);
    chk("R9 irq low w/o enable", {31'd0, irq}, 32'd0);
    wr(2'd1, 32'd0);
    chk("R8 write zero to set ignored", {31'd0, irq}, 32'd0);
    wr(2'd1, 32'd1);
    chk("R9 irq high", {31'd0, irq}, 32'd1);
    begin
      logic [31:0] d;
      rd(2'd2, d);
      chk("R8 enable reads at clear addr", d, 32'd1);
    end
    wr(2'd2, 32'd0);
    chk("R8 write zero to clear ignored", {31'd0, irq}, 32'd1);
    wr(2'd3, 32'd0);
    evt_is("R7 ack clears", 1'b0);
    chk("R9 irq low after ack", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'd1);
    begin
      logic [31:0] d;
      rd(2'd1, d);
      chk("R8 enable cleared", d, 32'd0);
    end
  endtask

  task automatic t_disabled;
    arm(cfg(2'd0, 20, 1'b0, 2'd3));
    set_pin(1'b0, 20, 1'b1);
    idle(5);
    evt_is("R10 mode 0 no event", 1'b0);
    arm(cfg(2'd1, 20, 1'b0, 2'd2));
    set_pin(1'b0, 20, 1'b0);
    idle(5);
    evt_is("R10 event before disable", 1'b1);
    wr(2'd0, cfg(2'd2, 20, 1'b0, 2'd3));
    set_pin(1'b0, 20, 1'b1);
    idle(5);
    evt_is("R10 flag held when disabled", 1'b1);
    wr(2'd3, 32'd0);
  endtask

  task automatic t_reselect;
    set_pin(1'b0, 25, 1'b1);
    arm(cfg(2'd1, 26, 1'b0, 2'd3));
    wr(2'd0, cfg(2'd1, 25, 1'b0, 2'd3));
    idle(6);
    evt_is("R11 reselect no event", 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_cfg_readback();
    t_rise();
    t_fall();
    t_toggle_none();
    t_bank_select();
    t_sticky_irq();
    t_disabled();
    t_reselect();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule